// File: doc/BRIEF.md
# Two-Bank Vectored Interrupt Resolver

This block merges two 32-line interrupt banks into a single prioritized interrupt decision. Each of the 64 level-sensitive request lines is gated by its own enable bit. Each bank also holds 16 programmable vector slots, and each slot pairs an enable flag with the number of the line it watches. A line picked up by an enabled slot is served through the vectored path. Any other pending line is served through the unvectored path of its bank.

The outcome is published as one shared tagged vector word, together with an interrupt request output. A handler reads the word once to learn which path won and, for a vectored win, which line it was. Vectored slots of bank 0 rank first, then vectored slots of bank 1, then unvectored lines of bank 0, then unvectored lines of bank 1. The slots are programmed through a simple single-cycle write strobe.

Top module: `irq_vector_resolver`

## Requirements
- R1: After reset the vector word is 0x000, the request output is low and every vector slot is disabled, so any pending line is resolved through the unvectored path.
- R2: A line counts as pending only while both its raw input and its enable bit are 1. A line whose enable bit is 0 has no effect on either output.
- R3: When a vectored slot wins, the vector word is 0x100 with the winning line number (0 to 63) in bits 5:0, and bits 7:6 and 10:9 are zero. For example, line 24 reads as 0x118.
- R4: Among vectored matches, every bank 0 slot outranks every bank 1 slot. Within a bank, the lower slot index wins.
- R5: Any vectored match outranks every unvectored pending line, in either bank.
- R6: If no slot matches and any pending line lies in 0 to 31 (bank 0), the vector word is exactly 0x200.
- R7: If no slot matches, no bank 0 line is pending, and a line in 32 to 63 (bank 1) is pending, the vector word is exactly 0x400.
- R8: With no pending line, the vector word is 0x000.
- R9: A slot never matches while it is disabled, or while its line number lies outside its own bank (bank 0 slots take 0 to 31, bank 1 slots take 32 to 63).
- R10: The vector word and the request output are registered. They reflect the inputs present at the previous rising clock edge, and the request output is 1 exactly when the vector word is nonzero.
- R11: A slot write (`slot_we`=1) loads `slot_on` and `slot_line` into slot `slot_sel` of bank `slot_bank` at the clock edge. The new setting shows in the vector word one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_raw | input | 64 | Level-sensitive raw request lines; 0 to 31 belong to bank 0, 32 to 63 to bank 1 |
| irq_en | input | 64 | Per-line enable bits |
| slot_we | input | 1 | Slot write strobe |
| slot_bank | input | 1 | Bank being programmed (0 or 1) |
| slot_sel | input | 4 | Slot index within that bank |
| slot_on | input | 1 | Enable flag written to the slot |
| slot_line | input | 6 | Line number written to the slot |
| irq_req | output | 1 | Registered interrupt request |
| vec_word | output | 11 | Registered tagged vector word |

## Verification
The embedded assertions guard the form of the output on every cycle. Only one of the three tag bits may be set. An unvectored word has clean low bits. A vectored word names a line that was really pending. The bank 1 unvectored tag may appear only when bank 0 had nothing pending. The request output must track a nonzero word, and no pending lines must mean a zero word. What the assertions cannot show is which candidate ought to win. The bench covers that through a one-hot sweep of all 64 lines, a sweep of every pair of lines against a fixed slot programming (including slots that are disabled or point outside their bank), randomized masks, reprogramming of slots, and a check that the outputs stay unchanged until the clock edge.

// File: rtl/irq_vector_resolver.sv
`timescale 1ns/1ps
module irq_vector_resolver #(
  parameter int NLINE = 32,
  parameter int NSLOT = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [2*NLINE-1:0]              irq_raw,
  input  logic [2*NLINE-1:0]              irq_en,
  input  logic                            slot_we,
  input  logic                            slot_bank,
  input  logic [$clog2(NSLOT)-1:0]        slot_sel,
  input  logic                            slot_on,
  input  logic [$clog2(2*NLINE)-1:0]      slot_line,
  output logic                            irq_req,
  output logic [10:0]                     vec_word
);
  localparam int IDW = $clog2(2*NLINE);
  localparam int PAD = 8 - IDW;

  logic [NSLOT-1:0] s_on  [2];
  logic [IDW-1:0]   s_num [2][NSLOT];
  logic [2*NLINE-1:0] pend, pend_q;
  logic [10:0] vec_nxt;

  assign pend = irq_raw & irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++) begin
        s_on[b] <= '0;
        for (int s = 0; s < NSLOT; s++) s_num[b][s] <= '0;
      end
    end else if (slot_we) begin
      s_on[slot_bank][slot_sel]  <= slot_on;
      s_num[slot_bank][slot_sel] <= slot_line;
    end
  end

  always_comb begin
    logic found;
    found   = 1'b0;
    vec_nxt = '0;
    for (int b = 0; b < 2; b++)
      for (int s = 0; s < NSLOT; s++)
        if (!found && s_on[b][s] && (s_num[b][s][IDW-1] == b[0]) && pend[s_num[b][s]]) begin
          found   = 1'b1;
          vec_nxt = {3'b001, {PAD{1'b0}}, s_num[b][s]};
        end
    if (!found) begin
      if (|pend[NLINE-1:0])            vec_nxt = 11'h200;
      else if (|pend[2*NLINE-1:NLINE]) vec_nxt = 11'h400;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_word <= '0;
      irq_req  <= 1'b0;
      pend_q   <= '0;
    end else begin
      vec_word <= vec_nxt;
      irq_req  <= |vec_nxt;
      pend_q   <= pend;
    end
  end

  // R10
  req_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req == (vec_word != 11'h000));

  // R3
  tag_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(vec_word[10:8]));

  // R3
  vec_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_word[8] |-> (pend_q[vec_word[IDW-1:0]] && vec_word[7:IDW] == '0));

  // R6
  bank0_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_word[9] |-> (|pend_q[NLINE-1:0] && vec_word[7:0] == 8'h00));

  // R7
  bank1_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_word[10] |-> (pend_q[NLINE-1:0] == '0 && |pend_q[2*NLINE-1:NLINE] && vec_word[7:0] == 8'h00));

  // R8
  idle_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q == '0) |-> (vec_word == 11'h000));
endmodule

// File: tb/test_irq_vector_resolver.sv
`timescale 1ns/1ps
module test_irq_vector_resolver;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [63:0] irq_raw = '0, irq_en = '0;
  logic slot_we = 1'b0, slot_bank = 1'b0, slot_on = 1'b0;
  logic [3:0] slot_sel = '0;
  logic [5:0] slot_line = '0;
  logic irq_req;
  logic [10:0] vec_word;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  logic       m_on  [2][16];
  logic [5:0] m_num [2][16];

  always #2 clk = ~clk;

  irq_vector_resolver i_irq_vector_resolver (
    .clk(clk), .rst_n(rst_n), .irq_raw(irq_raw), .irq_en(irq_en),
    .slot_we(slot_we), .slot_bank(slot_bank), .slot_sel(slot_sel),
    .slot_on(slot_on), .slot_line(slot_line),
    .irq_req(irq_req), .vec_word(vec_word));

  function automatic logic [10:0] model(logic [63:0] r, logic [63:0] m);
    logic [63:0] p = r & m;
    for (int b = 0; b < 2; b++)
      for (int s = 0; s < 16; s++)
        if (m_on[b][s] && m_num[b][s][5] == b[0] && p[m_num[b][s]])
          return 11'h100 | 11'(m_num[b][s]);
    if (|p[31:0])  return 11'h200;
    if (|p[63:32]) return 11'h400;
    return 11'h000;
  endfunction

  task automatic chk(string tag, logic [10:0] exp);
    n_run++;
    if (vec_word !== exp || irq_req !== (exp != 0)) begin
      n_fail++;
      $display("FAIL %s: vec=%h req=%b expected vec=%h req=%b", tag, vec_word, irq_req, exp, exp != 0);
    end
  endtask

  task automatic apply(logic [63:0] r, logic [63:0] m, string tag);
    irq_raw = r; irq_en = m;
    @(negedge clk);
    chk(tag, model(r, m));
  endtask

  task automatic prog(bit b, int s, bit on, int ln);
    slot_we = 1'b1; slot_bank = b; slot_sel = 4'(s); slot_on = on; slot_line = 6'(ln);
    @(negedge clk);
    slot_we = 1'b0;
    m_on[b][s] = on; m_num[b][s] = 6'(ln);
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #600000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
    end
  end

  initial begin
    for (int b = 0; b < 2; b++)
      for (int s = 0; s < 16; s++) begin m_on[b][s] = 1'b0; m_num[b][s] = '0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", 11'h000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", 11'h000);
    // R1: slots start disabled, so line 24 resolves unvectored
    apply(64'h1 << 24, '1, "R1");

    // R6 R7 R2 R8: one-hot sweep, enabled then masked
    for (int l = 0; l < 64; l++) begin
      apply(64'h1 << l, '1, l < 32 ? "R6" : "R7");
      apply(64'h1 << l, ~(64'h1 << l), "R2 R8");
    end
    apply('0, '1, "R8");

    // R11: program slots, including disabled and out-of-bank ones
    prog(0, 0, 1, 20);
    prog(0, 3, 1, 5);
    prog(0, 5, 1, 40);
    prog(1, 0, 0, 50);
    prog(1, 1, 1, 56);
    prog(1, 2, 1, 33);
    prog(1, 4, 1, 10);
    prog(0, 9, 1, 24);
    apply(64'h1 << 24, '1, "R11 R3");

    // R3 R9: one-hot sweep with slots active
    for (int l = 0; l < 64; l++)
      apply(64'h1 << l, '1, "R3 R9");

    // R4 R5: every pair of lines
    for (int a = 0; a < 64; a++)
      for (int c = a + 1; c < 64; c++)
        apply((64'h1 << a) | (64'h1 << c), '1, "R4 R5");

    // R2 R4: randomized lines and masks
    for (int k = 0; k < 400; k++)
      apply({$urandom, $urandom}, {$urandom, $urandom}, "R2 R4");

    // R10: output holds until the next edge
    apply(64'h1 << 45, '1, "R10");
    irq_raw = 64'h1 << 5;
    #1 chk("R10", 11'h400);
    @(negedge clk);
    chk("R10", 11'h105);

    // R9 R11: disabling and retargeting slots
    prog(0, 3, 0, 5);
    apply(64'h1 << 5, '1, "R9");
    prog(1, 2, 1, 3);
    apply((64'h1 << 3) | (64'h1 << 33), '1, "R9");
    prog(1, 2, 1, 33);
    apply((64'h1 << 3) | (64'h1 << 33), '1, "R11");

    done = 1'b1;
    finish_run();
  end
endmodule